// File: doc/BRIEF.md
# ADC Control and Result Register Interface

This block is the digital front end of an eight-channel, 10-bit analog-to-digital converter. It sits on a byte-wide CPU register bus. Software writes a control/status register that holds an enable bit, an amplifier-path select bit and a 3-bit channel number. Setting the enable bit powers the converter and starts free-running conversion of the selected channel. Every conversion lasts a fixed number of clock cycles. At its last cycle the block captures the modelled analog sample, which arrives as a 10-bit code plus over-range and under-range flags. It saturates the captured value, latches it as one result and raises a completion flag.

Software can read the result in two ways. A 10-bit read polls the flag, reads the low byte (two LSBs) and then reads the high byte (eight MSBs). An 8-bit read polls the flag and reads only the high byte. Reading the high byte clears the flag. Reading the low byte does not clear it. Between a low-byte read and the following high-byte read the result pair is locked. A conversion that finishes during that window is held back and applied once the high byte has been read. This guarantees that both bytes come from the same conversion.

Top module: `adc_regif`

## Requirements
- R1: After reset, every register reads 00h. The converter is unpowered, the amplifier path is off and the active channel is 0.
- R2: Register address 0 is control/status. In that register, bit 5 is enable, bit 4 is amplifier select and bits 2:0 are the channel; these bits read back as written. Bit 7 is the completion flag and cannot be written. Bits 6 and 3 read 0. Addresses 1 (high byte) and 2 (low byte) cannot be written; writes to them have no effect. Address 3 reads 00h.
- R3: One write that sets enable starts continuous conversion. The completion flag reads 1 exactly CONV_CYCLES clock cycles after the write edge. Conversions then repeat every CONV_CYCLES cycles with no further write.
- R4: The high data register holds result bits 9:2. The low data register holds result bits 1:0 in its bits 1:0, and its bits 7:2 read 0.
- R5: With the over-range flag set, the result is full scale (FFh high, 03h low) whatever the code is. With only the under-range flag set, the result is 00h/00h. When both flags are set, over-range wins.
- R6: A read of the high byte clears the completion flag. A read of the low byte leaves the flag unchanged.
- R7: After a low-byte read, the data registers do not change until the high byte has been read. A conversion that completes in that window is applied, and sets the flag, on the cycle of the high-byte read.
- R8: Clearing enable aborts the conversion in progress: no result is produced, and the completion flag keeps its value.
- R9: The active-channel output takes a new channel field value only at the start of a conversion, never in the middle of one.
- R10: The amplifier-path output is high exactly when both enable and amplifier select are set. It rises on the same cycle as the power output, with no additional delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| smp_code | input | 10 | Modelled analog sample code |
| smp_over | input | 1 | Sample is above the upper reference |
| smp_under | input | 1 | Sample is below the lower reference |
| adc_power | output | 1 | Converter powered (enable bit) |
| amp_path_on | output | 1 | Amplified input path selected and powered |
| conv_chan | output | 3 | Channel of the conversion in progress |

## Verification
The hardest situation to reach is a conversion that completes while the result pair is locked between a low-byte read and the following high-byte read. The bench reaches it by reading the low byte and then changing the sample input. It then waits several full conversion periods before reading the high byte. That read must return the old upper bits, and the flag must then show the held-back result. The abort case is reached by clearing enable a few cycles before a conversion would end. The mid-conversion channel change is timed by counting edges from the enable write.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int BIT_DONE = 7;
    localparam int BIT_EN   = 5;
    localparam int BIT_AMP  = 4;

endpackage

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int CONV_CYCLES = 16,
    parameter int CH_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [CH_W-1:0] chan_i,
    output logic            start_o,
    output logic            done_o,
    output logic [CH_W-1:0] conv_chan_o
);
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  chan;
    } seq_t;

    seq_t st_q, st_d;
    logic start_w, done_w;

    always_comb begin
        st_d    = st_q;
        start_w = en_i && (st_q.cnt == '0);
        done_w  = en_i && (st_q.cnt == LAST);
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (done_w) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (start_w) begin
            st_d.chan = chan_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o     = start_w;
    assign done_o      = done_w;
    assign conv_chan_o = st_q.chan;

endmodule

// File: rtl/adc_result_path.sv
module adc_result_path #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RES_W-1:0] code_i,
    input  logic             over_i,
    input  logic             under_i,
    input  logic             lo_rd_i,
    input  logic             hi_rd_i,
    output logic [7:0]       data_hi_o,
    output logic [7:0]       data_lo_o,
    output logic             eoc_o,
    output logic             pend_o
);
    localparam int HI_W = 8;
    localparam int LO_W = RES_W - HI_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [RES_W-1:0] held;
        logic             held_vld;
        logic             lock;
        logic             eoc;
    } rp_t;

    rp_t rp_q, rp_d;
    logic [RES_W-1:0] sat_w;

    always_comb begin
        if (over_i) begin
            sat_w = '1;
        end else if (under_i) begin
            sat_w = '0;
        end else begin
            sat_w = code_i;
        end
    end

    always_comb begin
        rp_d = rp_q;
        if (lo_rd_i) begin
            rp_d.lock = 1'b1;
        end
        if (hi_rd_i) begin
            rp_d.lock = 1'b0;
            rp_d.eoc  = 1'b0;
            if (rp_q.held_vld) begin
                rp_d.res      = rp_q.held;
                rp_d.held_vld = 1'b0;
                rp_d.eoc      = 1'b1;
            end
        end
        if (done_i) begin
            if ((rp_q.lock || lo_rd_i) && !hi_rd_i) begin
                rp_d.held     = sat_w;
                rp_d.held_vld = 1'b1;
            end else begin
                rp_d.res = sat_w;
                rp_d.eoc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign data_hi_o = rp_q.res[RES_W-1 -: HI_W];
    assign data_lo_o = {{(8-LO_W){1'b0}}, rp_q.res[LO_W-1:0]};
    assign eoc_o     = rp_q.eoc;
    assign pend_o    = rp_q.held_vld;

endmodule

// File: rtl/adc_csr.sv
module adc_csr
    import adc_regif_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              eoc_i,
    input  logic [7:0]        data_hi_i,
    input  logic [7:0]        data_lo_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              en_o,
    output logic              amp_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              lo_rd_o,
    output logic              hi_rd_o
);
    typedef struct packed {
        logic            en;
        logic            amp;
        logic [CH_W-1:0] chan;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    reg_sel_e sel_w;
    logic [BUS_W-1:0] ctl_view_w;

    always_comb begin
        sel_w = reg_sel_e'(addr_i);
        ctl_d = ctl_q;
        if (wr_i && sel_w == SEL_CTRL) begin
            ctl_d.en   = wdata_i[BIT_EN];
            ctl_d.amp  = wdata_i[BIT_AMP];
            ctl_d.chan = wdata_i[CH_W-1:0];
        end
    end

    always_comb begin
        ctl_view_w                = '0;
        ctl_view_w[BIT_DONE]      = eoc_i;
        ctl_view_w[BIT_EN]        = ctl_q.en;
        ctl_view_w[BIT_AMP]       = ctl_q.amp;
        ctl_view_w[CH_W-1:0]      = ctl_q.chan;
        case (sel_w)
            SEL_CTRL: rdata_o = ctl_view_w;
            SEL_HIGH: rdata_o = data_hi_i;
            SEL_LOW:  rdata_o = data_lo_i;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign en_o    = ctl_q.en;
    assign amp_o   = ctl_q.amp;
    assign chan_o  = ctl_q.chan;
    assign lo_rd_o = rd_i && (sel_w == SEL_LOW);
    assign hi_rd_o = rd_i && (sel_w == SEL_HIGH);

endmodule

// File: rtl/adc_regif.sv
module adc_regif #(
    parameter int CONV_CYCLES = 16,
    parameter int RES_W       = 10,
    parameter int CH_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [RES_W-1:0] smp_code,
    input  logic             smp_over,
    input  logic             smp_under,
    output logic             adc_power,
    output logic             amp_path_on,
    output logic [CH_W-1:0]  conv_chan
);
    logic            en_w, amp_w, lo_rd_w, hi_rd_w;
    logic [CH_W-1:0] chan_w;
    logic            start_w, done_w, eoc_w, pend_w;
    logic [7:0]      data_hi_w, data_lo_w;

    adc_csr #(.CH_W(CH_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .wdata_i   (bus_wdata),
        .eoc_i     (eoc_w),
        .data_hi_i (data_hi_w),
        .data_lo_i (data_lo_w),
        .rdata_o   (bus_rdata),
        .en_o      (en_w),
        .amp_o     (amp_w),
        .chan_o    (chan_w),
        .lo_rd_o   (lo_rd_w),
        .hi_rd_o   (hi_rd_w)
    );

    adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES), .CH_W(CH_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_w),
        .chan_i      (chan_w),
        .start_o     (start_w),
        .done_o      (done_w),
        .conv_chan_o (conv_chan)
    );

    adc_result_path #(.RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_w),
        .code_i    (smp_code),
        .over_i    (smp_over),
        .under_i   (smp_under),
        .lo_rd_i   (lo_rd_w),
        .hi_rd_i   (hi_rd_w),
        .data_hi_o (data_hi_w),
        .data_lo_o (data_lo_w),
        .eoc_o     (eoc_w),
        .pend_o    (pend_w)
    );

    assign adc_power   = en_w;
    assign amp_path_on = en_w & amp_w;

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hi_rd,
    input logic            lo_rd,
    input logic            done,
    input logic            start,
    input logic            pend,
    input logic            eoc,
    input logic            power,
    input logic [7:0]      data_hi,
    input logic [7:0]      data_lo,
    input logic [CH_W-1:0] chan
);
    // R6
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd && !done && !pend |=> !eoc);

    // R6
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd && !done |=> eoc == $past(eoc));

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power |-> !done);

    // R7
    bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done && !hi_rd |=> $stable({data_hi, data_lo}));

    // R9
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(chan));

    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done && !hi_rd |=> !$rose(eoc));

endmodule

bind adc_regif adc_regif_chk #(.CH_W(CH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_rd   (hi_rd_w),
    .lo_rd   (lo_rd_w),
    .done    (done_w),
    .start   (start_w),
    .pend    (pend_w),
    .eoc     (eoc_w),
    .power   (adc_power),
    .data_hi (data_hi_w),
    .data_lo (data_lo_w),
    .chan    (conv_chan)
);

// File: tb/adc_regif_test.sv
module adc_regif_test;
    localparam int CONV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [9:0] smp_code = '0;
    logic       smp_over = 1'b0;
    logic       smp_under = 1'b0;
    logic       adc_power, amp_path_on;
    logic [2:0] conv_chan;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    adc_regif #(.CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_code(smp_code), .smp_over(smp_over), .smp_under(smp_under),
        .adc_power(adc_power), .amp_path_on(amp_path_on), .conv_chan(conv_chan)
    );

    // code, over, under, expected high, expected low
    typedef struct packed {
        logic [9:0] code;
        logic       over;
        logic       under;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h3FF, 1'b0, 1'b0, 8'hFF, 8'h03},
        '{10'h000, 1'b0, 1'b0, 8'h00, 8'h00},
        '{10'h155, 1'b0, 1'b0, 8'h55, 8'h01},
        '{10'h2AA, 1'b0, 1'b0, 8'hAA, 8'h02},
        '{10'h203, 1'b0, 1'b0, 8'h80, 8'h03},
        '{10'h123, 1'b1, 1'b0, 8'hFF, 8'h03},
        '{10'h3FE, 1'b0, 1'b1, 8'h00, 8'h00},
        '{10'h0C3, 1'b1, 1'b1, 8'hFF, 8'h03}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic peek_flag();
        return bus_rdata[7];
    endfunction

    task automatic wait_flag(input string req);
        int n = 0;
        bus_addr = 2'd0;
        #1;
        while (!bus_rdata[7] && n < 4*CONV) begin
            @(negedge clk);
            #1;
            n++;
        end
        if (!bus_rdata[7]) check(req, 32'd0, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 8'h00);
        rd(2'd1, d); check("R1 high", d, 8'h00);
        rd(2'd2, d); check("R1 low", d, 8'h00);
        check("R1 power", {amp_path_on, adc_power, conv_chan}, 0);

        // R2 data registers not writable, spare address reads zero
        wr(2'd1, 8'hA5); wr(2'd2, 8'h5A);
        rd(2'd1, d); check("R2 high write ignored", d, 8'h00);
        rd(2'd2, d); check("R2 low write ignored", d, 8'h00);
        rd(2'd3, d); check("R2 spare address", d, 8'h00);

        // R10 amplifier without enable stays off
        wr(2'd0, 8'h10);
        check("R10 amp without enable", amp_path_on, 1'b0);
        // R2 readback of all bits, done flag not writable
        wr(2'd0, 8'hFF);
        check("R10 amp with enable", {adc_power, amp_path_on}, 2'b11);
        rd(2'd0, d); check("R2 ctrl readback", d, 8'h37);
        wr(2'd0, 8'h00);
        rd(2'd1, d);

        // R3 timing of first completion
        smp_code = 10'h155;
        wr(2'd0, 8'h20);
        repeat (CONV - 1) @(negedge clk);
        bus_addr = 2'd0; #1;
        check("R3 flag not yet", peek_flag(), 1'b0);
        @(negedge clk); #1;
        check("R3 flag at period", peek_flag(), 1'b1);
        @(negedge clk);

        // R6 low read keeps flag, high read clears; R4 split
        rd(2'd2, d); check("R4 low byte", d, 8'h01);
        bus_addr = 2'd0; #1;
        check("R6 low read keeps flag", peek_flag(), 1'b1);
        @(negedge clk);
        rd(2'd1, d); check("R4 high byte", d, 8'h55);
        bus_addr = 2'd0; #1;
        check("R6 high read clears flag", peek_flag(), 1'b0);
        @(negedge clk);
        // R3 continuous: flag returns without a new write
        wait_flag("R3 continuous");
        check("R3 continuous flag", 1'b1, 1'b1);

        // R4 R5 vector table
        foreach (VECS[i]) begin
            smp_code = VECS[i].code; smp_over = VECS[i].over; smp_under = VECS[i].under;
            rd(2'd1, d);
            wait_flag("R5 flag");
            rd(2'd2, d); check($sformatf("R5 vec%0d low", i), d, VECS[i].lo);
            rd(2'd1, d); check($sformatf("R5 vec%0d high", i), d, VECS[i].hi);
        end
        smp_over = 1'b0; smp_under = 1'b0;

        // R6 8-bit read sequence
        smp_code = 10'h0F0;
        rd(2'd1, d);
        wait_flag("R6 flag");
        rd(2'd1, d); check("R6 8-bit read", d, 8'h3C);

        // R7 pair lock across completions
        smp_code = 10'h155;
        rd(2'd1, d);
        wait_flag("R7 flag");
        rd(2'd2, d); check("R7 low byte", d, 8'h01);
        smp_code = 10'h2AA;
        repeat (3 * CONV) @(negedge clk);
        rd(2'd1, d); check("R7 high byte held", d, 8'h55);
        bus_addr = 2'd0; #1;
        check("R7 held result flagged", peek_flag(), 1'b1);
        @(negedge clk);
        rd(2'd2, d); check("R7 new low", d, 8'h02);
        rd(2'd1, d); check("R7 new high", d, 8'hAA);

        // R8 abort mid conversion
        wr(2'd0, 8'h00);
        rd(2'd1, d);
        wr(2'd0, 8'h20);
        repeat (CONV - 3) @(negedge clk);
        wr(2'd0, 8'h00);
        repeat (2 * CONV) @(negedge clk);
        bus_addr = 2'd0; #1;
        check("R8 abort no flag", peek_flag(), 1'b0);
        check("R8 power off", adc_power, 1'b0);
        @(negedge clk);
        wr(2'd0, 8'h20);
        wait_flag("R8 flag");
        wr(2'd0, 8'h00);
        repeat (2 * CONV) @(negedge clk);
        bus_addr = 2'd0; #1;
        check("R8 flag kept after disable", peek_flag(), 1'b1);
        @(negedge clk);

        // R9 channel change deferred to next start
        wr(2'd0, 8'h23);
        @(negedge clk);
        check("R9 first channel", conv_chan, 3'd3);
        wr(2'd0, 8'h25);
        check("R9 channel held mid conversion", conv_chan, 3'd3);
        repeat (CONV) @(negedge clk);
        check("R9 channel at next start", conv_chan, 3'd5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule